// File: doc/BRIEF.md
# Operand Pairing Unit with Explicit Token Store

This block sits between the token router and the execution unit of a small dataflow processor. Each incoming token carries a 16-bit value and a destination made of a node number and an operand side (left or right). The unit keeps one value slot per node, with a presence flag. The first token that reaches a node is parked in that node's slot. The second token completes the pair.

When a pair completes, the unit reads the node's program entry. That entry holds an opcode and up to four destinations, each with its own valid flag. The unit then emits one packet to the execution unit. The packet carries the left and right operand values, the opcode and the destination list. Only values are stored. The program entry is looked up with the node number of the completing token.

The program store is filled through a dedicated write port before execution starts. The unit reads tokens from a first-word-fall-through input FIFO and pulses the FIFO read line for each token it takes. It takes no token while the execution unit's input buffer reports full.

Top module: `token_pair_matcher`

## Requirements
- R1: An active-low reset clears every presence flag. After reset, the first token sent to any node is parked and no packet is produced.
- R2: A token taken while its node's slot is empty is stored there. No packet follows it (out_valid stays 0 in the next cycle).
- R3: A token taken while its node's slot is occupied produces exactly one packet, with out_valid high in the cycle after the token is taken. The slot becomes empty again, so the next token to that node is parked.
- R4: Operand order follows the side bit (0 = left, 1 = right), not arrival order. The left token's value appears on out_opa and the right token's value on out_opb.
- R5: A packet carries the opcode and the destination list stored for the node of the completing token. The opcode codes are 0 = add, 1 = subtract, 2 = multiply. Destination slot i occupies out_dest_node[7*i+6:7*i], out_dest_side[i] and out_dest_valid[i].
- R6: While exu_full is 1, no token is taken: in_read stays 0, no packet is produced and no slot changes.
- R7: in_read is 1 in exactly the cycles where in_valid is 1 and exu_full is 0. Every such cycle consumes one token.
- R8: A write on the program port (prog_we = 1) replaces the node's entry from the next clock edge. A later match on that node emits the new contents.
- R9: Slots are separate per node. Tokens sent to different nodes never pair with each other.
- R10: out_valid is a one-cycle pulse per match. It is 0 in any cycle that does not follow a matching token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input FIFO holds a token |
| in_value | input | 16 | Token value |
| in_node | input | 7 | Destination node number |
| in_side | input | 1 | Destination side, 0 left, 1 right |
| in_read | output | 1 | Token taken from FIFO this cycle |
| exu_full | input | 1 | Execution unit input buffer full |
| out_valid | output | 1 | Packet valid (one cycle) |
| out_opa | output | 16 | Left operand |
| out_opb | output | 16 | Right operand |
| out_opcode | output | 2 | Opcode of matched node |
| out_dest_valid | output | 4 | Valid flag per destination slot |
| out_dest_node | output | 28 | Node numbers of the four destination slots |
| out_dest_side | output | 4 | Sides of the four destination slots |
| prog_we | input | 1 | Program entry write strobe |
| prog_addr | input | 7 | Node number being programmed |
| prog_opcode | input | 2 | Opcode to store |
| prog_dest_valid | input | 4 | Destination valid flags to store |
| prog_dest_node | input | 28 | Destination node numbers to store |
| prog_dest_side | input | 4 | Destination sides to store |

## Verification
A wrong presence flag shows up at the ports on the very next token sent to that node. A stale set flag produces a packet one cycle after the first token, and a lost flag suppresses the packet that the second token should produce. A flag corrupted by a blocked or foreign token shows up as a missing packet, or as an extra packet with wrong operands, on the following token to the affected node. A corrupted stored value or program entry is visible only in the packet fields of the next match on that node. The bench therefore completes every parked token and compares each packet field.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int VAL_W  = 16;
  localparam int NODES  = 128;
  localparam int NDEST  = 4;
  localparam int NODE_W = $clog2(NODES);
  localparam int OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_RSV = 2'd3
  } opcode_e;

  localparam logic SIDE_LEFT = 1'b0;

  typedef struct packed {
    logic [NODE_W-1:0] node;
    logic              side;
  } dest_t;

  typedef struct packed {
    opcode_e               op;
    logic [NDEST-1:0]      dvalid;
    dest_t [NDEST-1:0]     dest;
  } prog_entry_t;
endpackage

// File: rtl/tpm_token_store.sv
module tpm_token_store
  import tpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] node,
  output logic              rd_present,
  output logic [VAL_W-1:0]  rd_value,
  input  logic              wr_en,
  input  logic              wr_fill,
  input  logic [VAL_W-1:0]  wr_value
);
  logic [NODES-1:0] pres_q, pres_d;
  logic [VAL_W-1:0] vals_q [NODES];

  // asynchronous read of the addressed slot
  assign rd_present = pres_q[node];
  assign rd_value   = vals_q[node];

  always_comb begin
    pres_d = pres_q;
    if (wr_en) pres_d[node] = wr_fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pres_q <= '0;
    else        pres_q <= pres_d;
  end

  // value array carries no reset; only the presence flags qualify it
  always_ff @(posedge clk) begin
    if (wr_en && wr_fill) vals_q[node] <= wr_value;
  end
endmodule

// File: rtl/tpm_prog_mem.sv
module tpm_prog_mem
  import tpm_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [NODE_W-1:0] waddr,
  input  prog_entry_t       wdata,
  input  logic [NODE_W-1:0] raddr,
  output prog_entry_t       rdata
);
  prog_entry_t mem_q [NODES];

  assign rdata = mem_q[raddr];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end
endmodule

// File: rtl/tpm_match_ctrl.sv
module tpm_match_ctrl
  import tpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VAL_W-1:0] in_value,
  input  logic             in_side,
  input  logic             exu_full,
  output logic             in_read,
  input  logic             st_present,
  input  logic [VAL_W-1:0] st_value,
  output logic             st_wr_en,
  output logic             st_fill,
  input  prog_entry_t      pm_entry,
  output logic             out_valid,
  output logic [VAL_W-1:0] out_opa,
  output logic [VAL_W-1:0] out_opb,
  output prog_entry_t      out_entry
);
  logic             take, fire;
  logic [VAL_W-1:0] opa_d, opb_d;
  logic             vld_q;
  logic [VAL_W-1:0] opa_q, opb_q;
  prog_entry_t      ent_q;

  always_comb begin
    take     = in_valid && !exu_full;
    fire     = take && st_present;
    in_read  = take;
    st_wr_en = take;
    st_fill  = !st_present;
    if (in_side == SIDE_LEFT) begin
      opa_d = in_value;
      opb_d = st_value;
    end else begin
      opa_d = st_value;
      opb_d = in_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= fire;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      opa_q <= opa_d;
      opb_q <= opb_d;
      ent_q <= pm_entry;
    end
  end

  assign out_valid = vld_q;
  assign out_opa   = opa_q;
  assign out_opb   = opb_q;
  assign out_entry = ent_q;
endmodule

// File: rtl/token_pair_matcher.sv
module token_pair_matcher
  import tpm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [VAL_W-1:0]        in_value,
  input  logic [NODE_W-1:0]       in_node,
  input  logic                    in_side,
  output logic                    in_read,
  input  logic                    exu_full,
  output logic                    out_valid,
  output logic [VAL_W-1:0]        out_opa,
  output logic [VAL_W-1:0]        out_opb,
  output logic [OP_W-1:0]         out_opcode,
  output logic [NDEST-1:0]        out_dest_valid,
  output logic [NDEST*NODE_W-1:0] out_dest_node,
  output logic [NDEST-1:0]        out_dest_side,
  input  logic                    prog_we,
  input  logic [NODE_W-1:0]       prog_addr,
  input  logic [OP_W-1:0]         prog_opcode,
  input  logic [NDEST-1:0]        prog_dest_valid,
  input  logic [NDEST*NODE_W-1:0] prog_dest_node,
  input  logic [NDEST-1:0]        prog_dest_side
);
  logic             st_present, st_wr_en, st_fill;
  logic [VAL_W-1:0] st_value;
  prog_entry_t      pm_wdata, pm_rdata, out_entry;

  assign pm_wdata.op     = opcode_e'(prog_opcode);
  assign pm_wdata.dvalid = prog_dest_valid;
  assign out_opcode      = out_entry.op;
  assign out_dest_valid  = out_entry.dvalid;

  for (genvar i = 0; i < NDEST; i++) begin : g_dest
    assign pm_wdata.dest[i].node = prog_dest_node[i*NODE_W +: NODE_W];
    assign pm_wdata.dest[i].side = prog_dest_side[i];
    assign out_dest_node[i*NODE_W +: NODE_W] = out_entry.dest[i].node;
    assign out_dest_side[i] = out_entry.dest[i].side;
  end

  tpm_token_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .node       (in_node),
    .rd_present (st_present),
    .rd_value   (st_value),
    .wr_en      (st_wr_en),
    .wr_fill    (st_fill),
    .wr_value   (in_value)
  );

  tpm_prog_mem u_prog (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (pm_wdata),
    .raddr (in_node),
    .rdata (pm_rdata)
  );

  tpm_match_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_value   (in_value),
    .in_side    (in_side),
    .exu_full   (exu_full),
    .in_read    (in_read),
    .st_present (st_present),
    .st_value   (st_value),
    .st_wr_en   (st_wr_en),
    .st_fill    (st_fill),
    .pm_entry   (pm_rdata),
    .out_valid  (out_valid),
    .out_opa    (out_opa),
    .out_opb    (out_opb),
    .out_entry  (out_entry)
  );
endmodule

// File: rtl/tpm_checker.sv
module tpm_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic exu_full,
  input logic in_read,
  input logic out_valid
);
  // R6: a full execution buffer blocks consumption
  assert_full_blocks_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exu_full |-> !in_read);

  // R7: a read only happens on an offered token
  assert_read_needs_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |-> in_valid);

  // R7: an offered token with room is always taken
  assert_read_when_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !exu_full) |-> in_read);

  // R3: a packet is always preceded by a consumed token
  assert_packet_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_read));

  // R10: no consumption means no packet in the next cycle
  assert_no_spurious_packet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_read |=> !out_valid);
endmodule

bind token_pair_matcher tpm_checker u_chk (.*);

// File: tb/sim_token_pair_matcher.sv
`timescale 1ns/1ps
module sim_token_pair_matcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_side, exu_full, prog_we;
  logic [15:0] in_value;
  logic [6:0]  in_node, prog_addr;
  logic [1:0]  prog_opcode;
  logic [3:0]  prog_dest_valid, prog_dest_side;
  logic [27:0] prog_dest_node;
  logic        in_read, out_valid;
  logic [15:0] out_opa, out_opb;
  logic [1:0]  out_opcode;
  logic [3:0]  out_dest_valid, out_dest_side;
  logic [27:0] out_dest_node;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  token_pair_matcher u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic program_node(input [6:0] n, input [1:0] op, input [3:0] dv,
                              input [27:0] dn, input [3:0] ds);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = n; prog_opcode = op;
    prog_dest_valid = dv; prog_dest_node = dn; prog_dest_side = ds;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  // offer one token, expect it taken; check the packet of the following cycle
  task automatic send(input string tag, input [15:0] v, input [6:0] n, input s,
                      input bit exp_pkt, input [15:0] ea, input [15:0] eb,
                      input [1:0] eop, input [3:0] edv, input [27:0] edn,
                      input [3:0] eds);
    @(negedge clk);
    in_valid = 1'b1; in_value = v; in_node = n; in_side = s;
    #0.5;
    check({tag, " R7 in_read"}, in_read, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " out_valid"}, out_valid, exp_pkt);
    if (exp_pkt) begin
      check({tag, " R4 opa"}, out_opa, ea);
      check({tag, " R4 opb"}, out_opb, eb);
      check({tag, " R5 opcode"}, out_opcode, eop);
      check({tag, " R5 dest_valid"}, out_dest_valid, edv);
      check({tag, " R5 dest_node"}, out_dest_node, edn);
      check({tag, " R5 dest_side"}, out_dest_side, eds);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R7 idle in_read", in_read, 0);
    check("R1 idle out_valid", out_valid, 0);
  endtask

  task automatic t_example_pairs();
    send("R2 n0 first", 16'd1, 7'd0, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    send("R3 n0 match", 16'd2, 7'd0, 1'b1, 1, 16'd1, 16'd2, 2'd0, 4'b0011,
         {7'd0, 7'd0, 7'd3, 7'd2}, 4'b0000);
    @(negedge clk);
    check("R10 pulse ends", out_valid, 0);
    send("R2 n1 first", 16'd3, 7'd1, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    send("R3 n1 match", 16'd4, 7'd1, 1'b1, 1, 16'd3, 16'd4, 2'd2, 4'b0011,
         {7'd0, 7'd0, 7'd3, 7'd2}, 4'b0011);
  endtask

  task automatic t_side_order();
    send("R4 n2 right first", 16'd12, 7'd2, 1'b1, 0, 0, 0, 0, 0, 0, 0);
    send("R4 n2 left second", 16'hfff7, 7'd2, 1'b0, 1, 16'hfff7, 16'd12, 2'd1,
         4'b0001, {21'd0, 7'd4}, 4'b0000);
  endtask

  task automatic t_independent_nodes();
    send("R9 n10 L", 16'd5, 7'd10, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    send("R9 n11 L", 16'd6, 7'd11, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    send("R9 n10 R", 16'd7, 7'd10, 1'b1, 1, 16'd5, 16'd7, 2'd0, 4'b0001,
         {21'd0, 7'd99}, 4'b0001);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    exu_full = 1'b1;
    in_valid = 1'b1; in_value = 16'd9; in_node = 7'd11; in_side = 1'b1;
    #0.5;
    check("R6 in_read blocked", in_read, 0);
    repeat (3) @(negedge clk);
    check("R6 no packet while full", out_valid, 0);
    check("R6 still blocked", in_read, 0);
    in_valid = 1'b0;
    exu_full = 1'b0;
    send("R6 n11 R after release", 16'd9, 7'd11, 1'b1, 1, 16'd6, 16'd9, 2'd2,
         4'b0001, {21'd0, 7'd12}, 4'b0000);
  endtask

  task automatic t_slot_reuse();
    send("R3 n10 reparked", 16'd20, 7'd10, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    send("R3 n10 second pair", 16'd21, 7'd10, 1'b1, 1, 16'd20, 16'd21, 2'd0,
         4'b0001, {21'd0, 7'd99}, 4'b0001);
  endtask

  task automatic t_reprogram();
    program_node(7'd10, 2'd2, 4'b1111, {7'd127, 7'd64, 7'd33, 7'd1}, 4'b1010);
    send("R8 n10 L", 16'd30, 7'd10, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    send("R8 n10 R", 16'd31, 7'd10, 1'b1, 1, 16'd30, 16'd31, 2'd2, 4'b1111,
         {7'd127, 7'd64, 7'd33, 7'd1}, 4'b1010);
  endtask

  task automatic t_reset_clears();
    send("R1 n20 park", 16'd1, 7'd20, 1'b0, 0, 0, 0, 0, 0, 0, 0);
    do_reset();
    send("R1 n20 after reset", 16'd2, 7'd20, 1'b1, 0, 0, 0, 0, 0, 0, 0);
    send("R1 n20 pairs", 16'd3, 7'd20, 1'b0, 1, 16'd3, 16'd2, 2'd1, 4'b0001,
         {21'd0, 7'd5}, 4'b0001);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    in_valid = 0; in_value = 0; in_node = 0; in_side = 0; exu_full = 0;
    prog_we = 0; prog_addr = 0; prog_opcode = 0; prog_dest_valid = 0;
    prog_dest_node = 0; prog_dest_side = 0;
    do_reset();
    t_reset_state();
    program_node(7'd0, 2'd0, 4'b0011, {7'd0, 7'd0, 7'd3, 7'd2}, 4'b0000);
    program_node(7'd1, 2'd2, 4'b0011, {7'd0, 7'd0, 7'd3, 7'd2}, 4'b0011);
    program_node(7'd2, 2'd1, 4'b0001, {21'd0, 7'd4}, 4'b0000);
    program_node(7'd10, 2'd0, 4'b0001, {21'd0, 7'd99}, 4'b0001);
    program_node(7'd11, 2'd2, 4'b0001, {21'd0, 7'd12}, 4'b0000);
    program_node(7'd20, 2'd1, 4'b0001, {21'd0, 7'd5}, 4'b0001);
    t_example_pairs();
    t_side_order();
    t_independent_nodes();
    t_backpressure();
    t_slot_reuse();
    t_reprogram();
    t_reset_clears();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule